// File: doc/BRIEF.md
# Link status and error counter monitor

This block sits beside a 10-gigabit Ethernet interface and turns its status levels and error strobes into values a host can read. It packs the live status levels into one 32-bit word. It keeps saturating counters for three error indications: receive bad frame, receive overrun and transmit overflow. It also watches a received packet stream, counts the packets that end, and counts packets whose length falls outside a programmable window. Packets shorter than the window and packets longer than the window go to separate counters.

The host reads through a small registered port. It places a word index on `rd_addr`, and one clock later `rd_data` holds that word as it stood at the clock edge. A synchronous clear input empties every counter without touching the status word.

Top module: `link_mon`

## Requirements
- R1: Word index 0 returns the status word. Bit 6 is `link_up`, bit 5 `rx_act`, bit 4 `tx_act`, bit 3 `tx_afull`, bit 2 `tx_ovf`, bit 1 `rx_bad` and bit 0 `rx_orun`. Bits 31 to 7 read as zero.
- R2: Word indices 1 to 6 return, zero-extended, the counters for bad frame (1), overrun (2), overflow (3), packets (4), oversize (5) and undersize (6). Index 7 returns zero.
- R3: Each error counter adds one on every clock cycle that its strobe is high. A strobe held high for N cycles adds N.
- R4: The packet counter adds one on each beat where `pkt_valid` and `pkt_eop` are both high.
- R5: Packet length is the number of valid beats from the `pkt_sop` beat through the `pkt_eop` beat, inclusive. A beat with both flags set has length 1. A length greater than `max_len` increments the oversize counter.
- R6: A length smaller than `min_len` increments the undersize counter. A length inside the window, bounds included, increments neither counter.
- R7: Each counter saturates at all ones and does not wrap.
- R8: `cnt_clr` high at a clock edge sets every counter to zero at that edge. This takes priority over any increment in the same cycle.
- R9: `rd_data` is registered. After the edge that samples `rd_addr`, it shows the selected word as it was just before that edge.
- R10: Synchronous `rst` sets all counters, the length tracker and `rd_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_clr | input | 1 | Synchronous counter clear |
| link_up | input | 1 | Link established level |
| rx_act | input | 1 | Receive activity level |
| tx_act | input | 1 | Transmit activity level |
| tx_afull | input | 1 | Transmit buffer almost full |
| tx_ovf | input | 1 | Transmit overflow strobe |
| rx_bad | input | 1 | Receive bad-frame strobe |
| rx_orun | input | 1 | Receive overrun strobe |
| pkt_valid | input | 1 | Receive FIFO output beat valid |
| pkt_sop | input | 1 | First beat of a packet |
| pkt_eop | input | 1 | Last beat of a packet |
| min_len | input | LEN_W | Smallest accepted length in beats |
| max_len | input | LEN_W | Largest accepted length in beats |
| rd_addr | input | 3 | Read word index |
| rd_data | output | 32 | Registered read word |

## Verification
The assertions assume a well-formed packet stream: each packet opens with a `pkt_sop` beat and closes with a `pkt_eop` beat, and every beat qualifies with `pkt_valid`. They also assume `min_len` does not exceed `max_len`, and that the limits stay still while a packet is in flight. The stimulus builds each packet as a contiguous run of valid beats with the flags placed on the first and last beat. It sets the limits once, before any packet starts. During a read it holds all strobes low, so the sampled word cannot move.

// File: rtl/link_mon.sv
module link_mon #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_clr,
  input  logic             link_up,
  input  logic             rx_act,
  input  logic             tx_act,
  input  logic             tx_afull,
  input  logic             tx_ovf,
  input  logic             rx_bad,
  input  logic             rx_orun,
  input  logic             pkt_valid,
  input  logic             pkt_sop,
  input  logic             pkt_eop,
  input  logic [LEN_W-1:0] min_len,
  input  logic [LEN_W-1:0] max_len,
  input  logic [2:0]       rd_addr,
  output logic [31:0]      rd_data
);
  localparam int NCNT = 6;
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [LEN_W-1:0] LMAX = '1;

  logic [CNT_W-1:0] cnt_q [NCNT];
  logic [LEN_W-1:0] len_q;
  logic [LEN_W:0]   cur_len;
  logic             eop_beat;
  logic [NCNT-1:0]  inc;
  logic [31:0]      status;

  assign status   = {25'd0, link_up, rx_act, tx_act, tx_afull, tx_ovf, rx_bad, rx_orun};
  assign eop_beat = pkt_valid & pkt_eop;
  assign cur_len  = pkt_sop ? (LEN_W+1)'(1) : {1'b0, len_q} + (LEN_W+1)'(1);
  assign inc = {eop_beat && cur_len < {1'b0, min_len},
                eop_beat && cur_len > {1'b0, max_len},
                eop_beat, tx_ovf, rx_orun, rx_bad};

  always_ff @(posedge clk) begin
    if (rst)
      len_q <= '0;
    else if (pkt_valid)
      len_q <= (pkt_sop || len_q != LMAX) ? cur_len[LEN_W-1:0] : len_q;
  end

  generate
    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst || cnt_clr)
          cnt_q[i] <= '0;
        else if (inc[i] && cnt_q[i] != CMAX)
          cnt_q[i] <= cnt_q[i] + CNT_W'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_addr == 3'd0)
      rd_data <= status;
    else if (rd_addr == 3'd7)
      rd_data <= '0;
    else
      rd_data <= 32'(cnt_q[rd_addr - 3'd1]);
  end
endmodule

module link_mon_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_clr,
  input logic             rx_bad,
  input logic             pkt_valid,
  input logic             pkt_eop,
  input logic [2:0]       rd_addr,
  input logic [31:0]      rd_data,
  input logic [31:0]      status,
  input logic [CNT_W-1:0] cnt_q [6]
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_status_r1: assert property (@(posedge clk) disable iff (rst)
    rd_addr == 3'd0 |=> rd_data[31:7] == 25'd0 && rd_data == $past(status));
  p_unused_r2: assert property (@(posedge clk) disable iff (rst)
    rd_addr == 3'd7 |=> rd_data == 32'd0);
  p_level_r3: assert property (@(posedge clk) disable iff (rst)
    rx_bad && !cnt_clr && cnt_q[0] != CMAX |=> cnt_q[0] == $past(cnt_q[0]) + CNT_W'(1));
  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !rx_bad && !cnt_clr |=> $stable(cnt_q[0]));
  p_pkt_r4: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && pkt_eop && !cnt_clr && cnt_q[3] != CMAX |=> cnt_q[3] == $past(cnt_q[3]) + CNT_W'(1));
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q[0] == CMAX && !cnt_clr |=> cnt_q[0] == CMAX);
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> cnt_q[0] == '0 && cnt_q[3] == '0 && cnt_q[4] == '0 && cnt_q[5] == '0);
endmodule

bind link_mon link_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .rx_bad(rx_bad),
  .pkt_valid(pkt_valid), .pkt_eop(pkt_eop), .rd_addr(rd_addr),
  .rd_data(rd_data), .status(status), .cnt_q(cnt_q)
);

// File: tb/test_link_mon.sv
`timescale 1ns/1ps
module test_link_mon;
  logic clk = 0, rst = 1, cnt_clr = 0;
  logic link_up = 0, rx_act = 0, tx_act = 0, tx_afull = 0;
  logic tx_ovf = 0, rx_bad = 0, rx_orun = 0;
  logic pkt_valid = 0, pkt_sop = 0, pkt_eop = 0;
  logic [15:0] min_len = 16'd4, max_len = 16'd8;
  logic [2:0] rd_addr = 0;
  logic [31:0] rd_data, rd_data_sat, v, vs;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  link_mon i_link_mon (.clk, .rst, .cnt_clr, .link_up, .rx_act, .tx_act, .tx_afull,
    .tx_ovf, .rx_bad, .rx_orun, .pkt_valid, .pkt_sop, .pkt_eop, .min_len, .max_len,
    .rd_addr, .rd_data);
  link_mon #(.CNT_W(4)) i_link_mon_sat (.clk, .rst, .cnt_clr, .link_up, .rx_act, .tx_act,
    .tx_afull, .tx_ovf, .rx_bad, .rx_orun, .pkt_valid, .pkt_sop, .pkt_eop, .min_len,
    .max_len, .rd_addr, .rd_data(rd_data_sat));

  // [9:2] length in beats, [1] oversize expected, [0] undersize expected (min 4, max 8)
  localparam logic [9:0] VEC [6] = '{
    {8'd1, 2'b01}, {8'd3, 2'b01}, {8'd4, 2'b00},
    {8'd8, 2'b00}, {8'd9, 2'b10}, {8'd20, 2'b10}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk) rd_addr = a;
    @(negedge clk) begin v = rd_data; vs = rd_data_sat; end
  endtask

  task automatic strobe(ref logic s, input int n);
    @(negedge clk) s = 1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk) s = 0;
  endtask

  task automatic send_pkt(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pkt_valid = 1; pkt_sop = (i == 0); pkt_eop = (i == n - 1);
    end
    @(negedge clk) begin pkt_valid = 0; pkt_sop = 0; pkt_eop = 0; end
  endtask

  task automatic clear;
    @(negedge clk) cnt_clr = 1;
    @(negedge clk) cnt_clr = 0;
  endtask

  initial begin
    int over = 0, under = 0;
    repeat (3) @(negedge clk);
    chk("R10 rd_data in reset", rd_data, 0);
    rst = 0;
    for (int a = 1; a <= 6; a++) begin
      rd(3'(a));
      chk("R10 counter zero after reset", v, 0);
    end

    @(negedge clk) begin link_up = 1; tx_act = 1; tx_afull = 1; rx_orun = 1; rd_addr = 0; end
    @(negedge clk) v = rd_data;
    chk("R1 status pattern A", v, 32'h59);
    @(negedge clk) begin link_up = 0; tx_act = 0; tx_afull = 0; rx_orun = 0;
      rx_act = 1; tx_ovf = 1; rx_bad = 1; end
    @(negedge clk) v = rd_data;
    chk("R1 status pattern B", v, 32'h26);
    @(negedge clk) begin rx_act = 0; tx_ovf = 0; rx_bad = 0; end
    rd(3'd7);
    chk("R2 unused index reads zero", v, 0);
    clear();

    strobe(rx_bad, 5);
    strobe(rx_orun, 3);
    strobe(tx_ovf, 4);
    strobe(tx_ovf, 3);
    rd(3'd1); chk("R3 bad-frame level count", v, 5);
    rd(3'd2); chk("R3 overrun level count", v, 3);
    rd(3'd3); chk("R3 overflow level count", v, 7);

    clear();
    foreach (VEC[k]) begin
      send_pkt(int'(VEC[k][9:2]));
      over += int'(VEC[k][1]);
      under += int'(VEC[k][0]);
      rd(3'd4); chk("R4 packet count", v, 32'(k + 1));
      rd(3'd5); chk("R5 oversize count", v, 32'(over));
      rd(3'd6); chk("R6 undersize count", v, 32'(under));
    end

    @(negedge clk) begin rx_bad = 1; cnt_clr = 1; end
    @(negedge clk) begin rx_bad = 0; cnt_clr = 0; end
    rd(3'd1); chk("R8 clear beats increment", v, 0);
    rd(3'd4); chk("R8 packet counter cleared", v, 0);

    @(negedge clk) rd_addr = 3'd1;
    @(negedge clk) rx_bad = 1;
    @(negedge clk) begin rx_bad = 0; v = rd_data; end
    chk("R9 read shows value before edge", v, 0);
    @(negedge clk) v = rd_data;
    chk("R9 read follows on next edge", v, 1);

    clear();
    strobe(rx_bad, 20);
    rd(3'd1);
    chk("R3 long burst count", v, 20);
    chk("R7 narrow counter saturates", vs, 15);

    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    rd(3'd1); chk("R10 reset clears counter", v, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule